// File: doc/BRIEF.md
# LCD Seven-Segment Latching Decoder

This block is the drive for one digit of a liquid-crystal readout. It stores a 4-bit 8421-coded digit and decodes it to the seven segment lines a to g. It also makes the square wave for the display's common backplane. The segment lines are registered and XOR-ed against that same square wave. A lit segment therefore always sits in antiphase with the backplane, and a dark segment follows it. The display sees a symmetric AC waveform and no net DC.

The digit store is transparent while `latchOpen` is high and holds its contents while `latchOpen` is low. The `blankIn` input darkens the whole digit. Codes 10 to 15 also darken it, so no hex glyphs appear. The `tickEn` input gates the square-wave divider. Each time it has been high for `HALF_PERIOD` clocks, the backplane flips. This keeps the duty cycle exactly 50%.

Top module: `lcdseg_driver`

## Requirements
- R1: While `latchOpen` is 1, each clock edge copies `bcdIn` into the digit store.
- R2: While `latchOpen` is 0, the digit store keeps its value, whatever `bcdIn` does.
- R3: Codes 0..9 produce these lit masks on bit 6..0 = g,f,e,d,c,b,a: 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F.
- R4: A stored code from 10 to 15 lights no segment.
- R5: While `blankIn` is 1, no segment is lit.
- R6: Every bit of `segOut` equals `backplane` XOR that segment's lit state. An unlit segment is in phase with the backplane, and a lit one is in antiphase.
- R7: `backplane` flips once for every `HALF_PERIOD` clock edges on which `tickEn` is 1. With `tickEn` held high, this gives a 50% duty cycle.
- R8: While `tickEn` is 0, `backplane` does not change.
- R9: `segOut` and `backplane` are both registers and update on the same edge. A new digit shows two edges after it is presented with `latchOpen` high. A change on `blankIn` shows one edge later.
- R10: A synchronous reset clears the digit store, sets `backplane` to 0 and drives `segOut` to 0. The digit stays dark until the first load through `latchOpen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bcdIn | input | 4 | 8421-coded digit |
| latchOpen | input | 1 | 1 = store transparent, 0 = hold |
| blankIn | input | 1 | 1 = darken all segments |
| tickEn | input | 1 | Enable for the backplane divider |
| segOut | output | 7 | Segment drive, bit 0 = a to bit 6 = g |
| backplane | output | 1 | Common backplane square wave |

## Verification
A corrupted digit store or a wrong decode entry appears as a wrong `segOut ^ {7{backplane}}` mask within two edges of the load. A blanking fault appears one edge after `blankIn` changes. A phase register that drifts from the segment inversion breaks the XOR relation at the very next edge. A miscounting divider changes the measured half-period within the first toggle seen.

// File: rtl/lcdseg_pkg.sv
package lcdseg_pkg;
  typedef struct packed {
    logic loadEn;     // capture bcdIn into the digit store
    logic phaseNext;  // phase value the registers take at this edge
  } ctrlStrobe_t;

  localparam int SEG_COUNT = 7;
  localparam int DIGIT_W   = 4;
endpackage

// File: rtl/lcdseg_ctrl.sv
module lcdseg_ctrl
  import lcdseg_pkg::*;
#(
  parameter int HALF_PERIOD = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        latchOpen,
  input  logic        tickEn,
  output ctrlStrobe_t strobe,
  output logic        backplane
);
  localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

  logic [CW-1:0] divCount;
  logic          phaseReg;
  logic          wrapNow;

  assign wrapNow = tickEn && (divCount == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      divCount <= '0;
      phaseReg <= 1'b0;
    end else if (tickEn) begin
      divCount <= wrapNow ? '0 : divCount + 1'b1;
      if (wrapNow) phaseReg <= ~phaseReg;
    end
  end

  always_comb begin
    strobe.loadEn    = latchOpen;
    strobe.phaseNext = wrapNow ? ~phaseReg : phaseReg;
  end

  assign backplane = phaseReg;

  // R7
  div_range_chk: assert property (@(posedge clk) disable iff (rst)
    divCount <= LAST);

  // R8
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tickEn |=> $stable(phaseReg));
endmodule

// File: rtl/lcdseg_datapath.sv
module lcdseg_datapath
  import lcdseg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  ctrlStrobe_t          strobe,
  input  logic [DIGIT_W-1:0]   bcdIn,
  input  logic                 blankIn,
  output logic [SEG_COUNT-1:0] segOut
);
  logic [DIGIT_W-1:0]   digitReg;
  logic                 validReg;
  logic [SEG_COUNT-1:0] litMask;
  logic [SEG_COUNT-1:0] segReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      digitReg <= '0;
      validReg <= 1'b0;
    end else if (strobe.loadEn) begin
      digitReg <= bcdIn;
      validReg <= 1'b1;
    end
  end

  always_comb begin
    unique case (digitReg)
      4'd0:    litMask = 7'h3F;
      4'd1:    litMask = 7'h06;
      4'd2:    litMask = 7'h5B;
      4'd3:    litMask = 7'h4F;
      4'd4:    litMask = 7'h66;
      4'd5:    litMask = 7'h6D;
      4'd6:    litMask = 7'h7D;
      4'd7:    litMask = 7'h07;
      4'd8:    litMask = 7'h7F;
      4'd9:    litMask = 7'h6F;
      default: litMask = 7'h00;
    endcase
    if (blankIn || !validReg) litMask = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) segReg <= '0;
    else     segReg <= litMask ^ {SEG_COUNT{strobe.phaseNext}};
  end

  assign segOut = segReg;

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadEn |=> $stable(digitReg));

  // R5
  blank_chk: assert property (@(posedge clk) disable iff (rst)
    blankIn |=> segReg == {SEG_COUNT{$past(strobe.phaseNext)}});

  // R4
  illegal_chk: assert property (@(posedge clk) disable iff (rst)
    (digitReg > 4'd9) |=> segReg == {SEG_COUNT{$past(strobe.phaseNext)}});
endmodule

// File: rtl/lcdseg_driver.sv
module lcdseg_driver
  import lcdseg_pkg::*;
#(
  parameter int HALF_PERIOD = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] bcdIn,
  input  logic       latchOpen,
  input  logic       blankIn,
  input  logic       tickEn,
  output logic [6:0] segOut,
  output logic       backplane
);
  ctrlStrobe_t strobe;

  lcdseg_ctrl #(.HALF_PERIOD(HALF_PERIOD)) ctrlInst (
    .clk(clk), .rst(rst), .latchOpen(latchOpen), .tickEn(tickEn),
    .strobe(strobe), .backplane(backplane)
  );

  lcdseg_datapath dpInst (
    .clk(clk), .rst(rst), .strobe(strobe), .bcdIn(bcdIn),
    .blankIn(blankIn), .segOut(segOut)
  );

  // R6
  seg_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $past(blankIn) |-> segOut == {7{backplane}});
endmodule

// File: tb/lcdseg_driver_test.sv
module lcdseg_driver_test;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] bcdIn;
  logic       latchOpen, blankIn, tickEn;
  logic [6:0] segOut;
  logic       backplane;

  int applied = 0;
  int miscompares = 0;
  bit done = 0;

  localparam int HALF = 4;
  localparam logic [6:0] LIT [16] = '{
    7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
    7'h7F, 7'h6F, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00};

  always #4 clk = ~clk;

  lcdseg_driver #(.HALF_PERIOD(HALF)) uut (
    .clk(clk), .rst(rst), .bcdIn(bcdIn), .latchOpen(latchOpen),
    .blankIn(blankIn), .tickEn(tickEn), .segOut(segOut), .backplane(backplane)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic stepClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [6:0] shownMask();
    return segOut ^ {7{backplane}};
  endfunction

  initial begin
    int toggles;
    int gap;
    logic lastBp;
    rst = 1; bcdIn = 4'd0; latchOpen = 0; blankIn = 0; tickEn = 0;
    stepClk(2);
    check("R10 reset seg", {1'b0, segOut}, 8'h00);
    check("R10 reset backplane", {7'b0, backplane}, 8'h00);
    rst = 0;
    stepClk(3);
    check("R10 dark before load", {1'b0, shownMask()}, 8'h00);

    // vector walk: every code, blank on and off, divider running (R1 R3 R4 R5 R6)
    tickEn = 1;
    for (int b = 0; b < 2; b++) begin
      for (int c = 0; c < 16; c++) begin
        bcdIn = 4'(c); blankIn = b[0]; latchOpen = 1;
        stepClk(2);
        check(b ? "R5 blank" : (c > 9 ? "R4 illegal" : "R3 R1 decode"),
              {1'b0, shownMask()}, {1'b0, b ? 7'h00 : LIT[c]});
      end
    end

    // R2 hold while latch closed
    blankIn = 0; bcdIn = 4'd8; latchOpen = 1; stepClk(2);
    latchOpen = 0; bcdIn = 4'd1; stepClk(3);
    check("R2 hold", {1'b0, shownMask()}, 8'h7F);
    bcdIn = 4'd12; stepClk(2);
    check("R2 hold illegal ignored", {1'b0, shownMask()}, 8'h7F);

    // R9 blank latency one edge
    blankIn = 1; stepClk(1);
    check("R9 blank one edge", {1'b0, shownMask()}, 8'h00);
    blankIn = 0; stepClk(1);
    check("R9 unblank one edge", {1'b0, shownMask()}, 8'h7F);

    // R9 digit latency two edges
    latchOpen = 1; bcdIn = 4'd4; stepClk(1);
    latchOpen = 0;
    check("R9 digit not yet shown", {1'b0, shownMask()}, 8'h7F);
    stepClk(1);
    check("R9 digit after two edges", {1'b0, shownMask()}, 8'h66);

    // R7 half period and R6 relation over many periods
    lastBp = backplane; gap = 0; toggles = 0;
    while (backplane == lastBp) stepClk(1);
    lastBp = backplane;
    for (int i = 0; i < 8 * HALF * 2; i++) begin
      stepClk(1); gap++;
      if (shownMask() !== 7'h66) check("R6 xor relation", {1'b0, shownMask()}, 8'h66);
      if (backplane != lastBp) begin
        toggles++;
        check("R7 half period", 8'(gap), 8'(HALF));
        gap = 0; lastBp = backplane;
      end
    end
    check("R7 toggle count", 8'(toggles), 8'd16);

    // R8 frozen divider
    tickEn = 0; lastBp = backplane;
    stepClk(3 * HALF);
    check("R8 backplane frozen", {7'b0, backplane}, {7'b0, lastBp});
    check("R6 frozen phase mask", {1'b0, shownMask()}, 8'h66);

    // R10 reset mid-run
    rst = 1; stepClk(1); rst = 0; stepClk(2);
    check("R10 reset again dark", {1'b0, segOut}, 8'h00);
    check("R10 reset phase", {7'b0, backplane}, 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      applied++; miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule